// File: doc/BRIEF.md
# 8-bit ALU with status-flag generation

This block is a purely combinational arithmetic and logic unit for an 8-bit datapath. It takes two operands, a 4-bit operation code and the present carry bit. It returns the operation result, a zero flag, a digit-carry flag (the carry out of the low nibble) and a carry flag. It also returns one write enable per flag. The enables feed the write mask of a status register that lives outside this block. A flag whose enable is low must keep its stored value, so this block drives that flag output to 0 and its value has no meaning.

Subtraction reuses the adder. It adds the inverted second operand with a carry-in of one. Carry and digit carry therefore read as "no borrow" after a subtraction. The two rotates pass through the carry bit. The block has no state, so it has no states or transitions. The same inputs always give the same outputs.

Operation codes: 0 add, 1 subtract, 2 AND, 3 OR, 4 XOR, 5 complement of A, 6 rotate right through carry, 7 rotate left through carry, 8 nibble swap of A, 9 move A, 10 move B, 11 set bit, 12 clear bit. Codes 13 to 15 behave as move A.

Top module: `alu_flag_gen`

## Requirements
- R1: Whenever the zero enable is 1, the zero flag is 1 exactly when the 8-bit result is 0x00.
- R2: For code 0 (add), the result is (A+B) mod 256 and the carry flag is 1 exactly when A+B exceeds 255.
- R3: For code 0, the digit-carry flag is 1 exactly when A[3:0]+B[3:0] exceeds 15.
- R4: For code 1 (subtract), the result is (A-B) mod 256 and the carry flag is 1 exactly when A >= B, treating both as unsigned (1 means no borrow).
- R5: For code 1, the digit-carry flag is 1 exactly when A[3:0] >= B[3:0].
- R6: Codes 2 to 5 give A&B, A|B, A^B and ~A respectively. Their only asserted enable is the zero enable.
- R7: For code 6 (rotate right), the result is {carry_in, A[7:1]}, the carry flag is A[0], and the only asserted enable is the carry enable.
- R8: For code 7 (rotate left), the result is {A[6:0], carry_in}, the carry flag is A[7], and the only asserted enable is the carry enable.
- R9: Codes 8 to 15 assert no enable. Code 8 gives {A[3:0],A[7:4]}. Code 9 gives A. Code 10 gives B. Code 11 gives A with bit B[2:0] set. Code 12 gives A with bit B[2:0] cleared. Codes 13 to 15 give A.
- R10: Codes 0 and 1 assert all three enables.
- R11: Every flag output is 0 while its enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 8 | First operand (source for rotates, swap and bit operations) |
| op_b | input | 8 | Second operand; bits 2:0 select the bit for set and clear |
| op_code | input | 4 | Operation selector |
| carry_in | input | 1 | Present carry bit, used by the rotates |
| result | output | 8 | Operation result |
| z_flag | output | 1 | Zero flag value |
| dc_flag | output | 1 | Digit carry / inverted digit borrow |
| c_flag | output | 1 | Carry / inverted borrow / rotated-out bit |
| z_wr | output | 1 | Zero flag write enable |
| dc_wr | output | 1 | Digit-carry flag write enable |
| c_wr | output | 1 | Carry flag write enable |

## Verification
The checker uses immediate assertions on the outputs of the combinational block. These assertions assume that all four inputs are known and change together, so the outputs are never observed partway through an update. The bench changes every input in one step at the falling clock edge. It compares the outputs one nanosecond later, once they have settled. Random stimulus covers all sixteen operation codes, including the three unused ones. Directed vectors cover the exact nibble and byte carry and borrow boundaries, along with rotates using both carry-in values.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_AND  = 4'd2,
        OP_OR   = 4'd3,
        OP_XOR  = 4'd4,
        OP_NOT  = 4'd5,
        OP_RRC  = 4'd6,
        OP_RLC  = 4'd7,
        OP_SWAP = 4'd8,
        OP_MOVA = 4'd9,
        OP_MOVB = 4'd10,
        OP_BSET = 4'd11,
        OP_BCLR = 4'd12,
        OP_RSV0 = 4'd13,
        OP_RSV1 = 4'd14,
        OP_RSV2 = 4'd15
    } alu_op_e;

    typedef struct packed {
        logic z;
        logic dc;
        logic c;
    } flag_set_t;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int WIDTH = 8,
    parameter int DIGIT = 4
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             sub,
    output logic [WIDTH-1:0] sum,
    output logic             digit_cy,
    output logic             byte_cy
);
    localparam int HIW = WIDTH - DIGIT;

    logic [WIDTH-1:0] b_eff;
    logic [DIGIT:0]   lo_sum;
    logic [HIW:0]     hi_sum;

    // Subtraction: add inverted operand plus one, carries become inverted borrows
    assign b_eff  = sub ? ~b : b;
    assign lo_sum = {1'b0, a[DIGIT-1:0]} + {1'b0, b_eff[DIGIT-1:0]}
                  + {{DIGIT{1'b0}}, sub};
    assign hi_sum = {1'b0, a[WIDTH-1:DIGIT]} + {1'b0, b_eff[WIDTH-1:DIGIT]}
                  + {{HIW{1'b0}}, lo_sum[DIGIT]};

    assign sum      = {hi_sum[HIW-1:0], lo_sum[DIGIT-1:0]};
    assign digit_cy = lo_sum[DIGIT];
    assign byte_cy  = hi_sum[HIW];
endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
    import alu_flag_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  alu_op_e          op,
    output logic [WIDTH-1:0] y
);
    localparam int IDXW = $clog2(WIDTH);
    localparam int HALF = WIDTH / 2;

    logic [WIDTH-1:0] bit_mask;

    assign bit_mask = {{(WIDTH-1){1'b0}}, 1'b1} << b[IDXW-1:0];

    always_comb begin
        unique case (op)
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            OP_NOT:  y = ~a;
            OP_SWAP: y = {a[HALF-1:0], a[WIDTH-1:HALF]};
            OP_MOVB: y = b;
            OP_BSET: y = a | bit_mask;
            OP_BCLR: y = a & ~bit_mask;
            default: y = a;
        endcase
    end
endmodule

// File: rtl/alu_rotate.sv
module alu_rotate #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic             cin,
    input  logic             left,
    output logic [WIDTH-1:0] y,
    output logic             cout
);
    generate
        if (WIDTH > 1) begin : g_wide
            always_comb begin
                if (left) begin
                    y    = {a[WIDTH-2:0], cin};
                    cout = a[WIDTH-1];
                end else begin
                    y    = {cin, a[WIDTH-1:1]};
                    cout = a[0];
                end
            end
        end else begin : g_single
            assign y    = cin;
            assign cout = a[0] & left | a[0] & ~left;
        end
    endgenerate
endmodule

// File: rtl/alu_flag_gen.sv
module alu_flag_gen
    import alu_flag_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int DIGIT = 4
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic [3:0]       op_code,
    input  logic             carry_in,
    output logic [WIDTH-1:0] result,
    output logic             z_flag,
    output logic             dc_flag,
    output logic             c_flag,
    output logic             z_wr,
    output logic             dc_wr,
    output logic             c_wr
);
    alu_op_e          op;
    logic [WIDTH-1:0] arith_y, logic_y, rot_y;
    logic             arith_dc, arith_c, rot_c;
    flag_set_t        wr_en, raw;

    assign op = alu_op_e'(op_code);

    alu_addsub #(.WIDTH(WIDTH), .DIGIT(DIGIT)) u_addsub (
        .a(op_a), .b(op_b), .sub(op == OP_SUB),
        .sum(arith_y), .digit_cy(arith_dc), .byte_cy(arith_c)
    );

    alu_logic_unit #(.WIDTH(WIDTH)) u_logic (
        .a(op_a), .b(op_b), .op(op), .y(logic_y)
    );

    alu_rotate #(.WIDTH(WIDTH)) u_rot (
        .a(op_a), .cin(carry_in), .left(op == OP_RLC),
        .y(rot_y), .cout(rot_c)
    );

    // Result select and flag write enables per operation class
    always_comb begin
        unique case (op)
            OP_ADD, OP_SUB: begin
                result = arith_y;
                wr_en  = '{z: 1'b1, dc: 1'b1, c: 1'b1};
            end
            OP_AND, OP_OR, OP_XOR, OP_NOT: begin
                result = logic_y;
                wr_en  = '{z: 1'b1, dc: 1'b0, c: 1'b0};
            end
            OP_RRC, OP_RLC: begin
                result = rot_y;
                wr_en  = '{z: 1'b0, dc: 1'b0, c: 1'b1};
            end
            default: begin
                result = logic_y;
                wr_en  = '{z: 1'b0, dc: 1'b0, c: 1'b0};
            end
        endcase
    end

    // Raw flag values before masking
    always_comb begin
        raw.z  = ~|result;
        raw.dc = arith_dc;
        raw.c  = wr_en.dc ? arith_c : rot_c;
    end

    assign z_wr    = wr_en.z;
    assign dc_wr   = wr_en.dc;
    assign c_wr    = wr_en.c;
    assign z_flag  = raw.z  & wr_en.z;
    assign dc_flag = raw.dc & wr_en.dc;
    assign c_flag  = raw.c  & wr_en.c;
endmodule

// File: rtl/alu_flag_gen_chk.sv
module alu_flag_gen_chk #(
    parameter int WIDTH = 8
) (
    input logic [WIDTH-1:0] op_a,
    input logic [WIDTH-1:0] op_b,
    input logic [3:0]       op_code,
    input logic             carry_in,
    input logic [WIDTH-1:0] result,
    input logic             z_flag,
    input logic             dc_flag,
    input logic             c_flag,
    input logic             z_wr,
    input logic             dc_wr,
    input logic             c_wr
);
    always_comb begin
        if (!$isunknown({op_a, op_b, op_code, carry_in})) begin
            if (z_wr)
                AST_ZERO_MATCH: assert (z_flag == (result == '0)) else $error("zero flag mismatch"); // R1
            if (op_code == 4'd0)
                AST_ADD_SUM: assert ({c_flag, result} == ({1'b0, op_a} + {1'b0, op_b})) else $error("add mismatch"); // R2
            if (op_code == 4'd1)
                AST_SUB_NOBORROW: assert (c_flag == (op_a >= op_b)) else $error("sub carry mismatch"); // R4
            if (op_code == 4'd6)
                AST_ROT_RIGHT: assert (result == {carry_in, op_a[WIDTH-1:1]} && c_flag == op_a[0]) else $error("rrc mismatch"); // R7
            if (op_code == 4'd7)
                AST_ROT_LEFT: assert (result == {op_a[WIDTH-2:0], carry_in} && c_flag == op_a[WIDTH-1]) else $error("rlc mismatch"); // R8
            if (op_code >= 4'd8)
                AST_QUIET_OPS: assert (!z_wr && !dc_wr && !c_wr) else $error("enable on quiet op"); // R9
            if (op_code <= 4'd1)
                AST_ARITH_ALL_EN: assert (z_wr && dc_wr && c_wr) else $error("arith enables"); // R10
            AST_MASKED_LOW: assert ((z_wr || !z_flag) && (dc_wr || !dc_flag) && (c_wr || !c_flag)) else $error("masked flag high"); // R11
        end
    end
endmodule

bind alu_flag_gen alu_flag_gen_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/tb_alu_flag_gen.sv
module tb_alu_flag_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] op_a = '0, op_b = '0;
    logic [3:0] op_code = 4'd9;
    logic       carry_in = 1'b0;
    logic [7:0] result;
    logic       z_flag, dc_flag, c_flag, z_wr, dc_wr, c_wr;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 0;

    always #10 clk = ~clk;

    alu_flag_gen dut (
        .op_a(op_a), .op_b(op_b), .op_code(op_code), .carry_in(carry_in),
        .result(result), .z_flag(z_flag), .dc_flag(dc_flag), .c_flag(c_flag),
        .z_wr(z_wr), .dc_wr(dc_wr), .c_wr(c_wr)
    );

    typedef struct packed {
        logic [7:0] res;
        logic [2:0] flg;
        logic [2:0] en;
    } exp_t;

    function automatic string tag_of(input int op);
        case (op)
            0: return "R2/R3";
            1: return "R4/R5";
            2, 3, 4, 5: return "R6";
            6: return "R7";
            7: return "R8";
            default: return "R9";
        endcase
    endfunction

    function automatic exp_t model(input int a, input int b, input int op, input int ci);
        exp_t e;
        int r = a;
        int z = 0, dc = 0, c = 0, zw = 0, dw = 0, cw = 0;
        int idx = b % 8;
        case (op)
            0: begin r = (a + b) % 256; c = (a + b > 255); dc = ((a % 16) + (b % 16) > 15); zw = 1; dw = 1; cw = 1; end
            1: begin r = (a - b + 256) % 256; c = (a >= b); dc = ((a % 16) >= (b % 16)); zw = 1; dw = 1; cw = 1; end
            2: begin r = a & b; zw = 1; end
            3: begin r = a | b; zw = 1; end
            4: begin r = a ^ b; zw = 1; end
            5: begin r = 255 - a; zw = 1; end
            6: begin r = (a / 2) + ci * 128; c = a % 2; cw = 1; end
            7: begin r = ((a * 2) % 256) + ci; c = a / 128; cw = 1; end
            8: r = ((a % 16) * 16) + (a / 16);
            10: r = b;
            11: r = a | (1 << idx);
            12: r = a & ~(1 << idx);
            default: r = a;
        endcase
        if (zw != 0) z = (r == 0);
        e.res = r[7:0];
        e.flg = {z[0], dc[0], c[0]};
        e.en  = {zw[0], dw[0], cw[0]};
        return e;
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic run_vec(input int a, input int b, input int op, input int ci);
        exp_t e;
        string t;
        @(negedge clk);
        op_a = a[7:0]; op_b = b[7:0]; op_code = op[3:0]; carry_in = ci[0];
        #1;
        e = model(a, b, op, ci);
        t = tag_of(op);
        check(t, "result", int'(result), int'(e.res));
        // R1 zero, R3/R5 digit carry, R11 masked flags read 0
        check({t, "/R1/R11"}, "flags", int'({z_flag, dc_flag, c_flag}), int'(e.flg));
        // R10 all enables for arithmetic, R6-R9 per-class enables
        check({t, "/R10"}, "enables", int'({z_wr, dc_wr, c_wr}), int'(e.en));
    endtask

    initial begin
        wait (done == 0);
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000 && !done) begin
                n_checks++; n_fail++;
                $display("FAIL watchdog: actual=%0d cycles expected=below 150000", cycles);
                $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        #1;
        // Idle vector present from time zero: move A of zero, no enables (R9, R11)
        check("R9", "idle result", int'(result), 0);
        check("R11", "idle flags", int'({z_flag, dc_flag, c_flag}), 0);

        // Directed corners
        run_vec(8'h0F, 8'h01, 0, 0);   // R3 nibble carry only
        run_vec(8'hFF, 8'h01, 0, 0);   // R1 R2 zero with carry
        run_vec(8'h80, 8'h80, 0, 1);   // R2 carry without nibble carry
        run_vec(8'h7F, 8'h00, 0, 0);
        run_vec(8'h05, 8'h05, 1, 0);   // R4 R5 equal: no borrow, zero
        run_vec(8'h00, 8'h01, 1, 1);   // R4 borrow
        run_vec(8'h10, 8'h01, 1, 0);   // R5 nibble borrow only
        run_vec(8'h34, 8'h12, 1, 0);
        run_vec(8'hF0, 8'h0F, 2, 0);   // R6 AND zero
        run_vec(8'h00, 8'h00, 3, 1);
        run_vec(8'hAA, 8'hAA, 4, 0);
        run_vec(8'hFF, 8'h00, 5, 1);
        for (int ci = 0; ci < 2; ci++) begin
            run_vec(8'h01, 8'h00, 6, ci); // R7
            run_vec(8'h80, 8'h00, 7, ci); // R8
            run_vec(8'h00, 8'h00, 6, ci);
        end
        run_vec(8'hA5, 8'h00, 8, 1);   // R9 swap
        run_vec(8'h00, 8'h07, 11, 0);  // R9 set top bit
        run_vec(8'hFF, 8'h00, 12, 1);  // R9 clear bit 0
        run_vec(8'h3C, 8'hC3, 10, 0);
        for (int op = 13; op < 16; op++) run_vec(8'h00, 8'h55, op, 1);

        // Constrained random: every code, full operand range
        for (int i = 0; i < 3000; i++) begin
            run_vec(int'($urandom_range(255)), int'($urandom_range(255)),
                    int'($urandom_range(15)), int'($urandom_range(1)));
        end

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule